// File: doc/BRIEF.md
# Chained Interrupt Priority Unit with Return-Opcode Snooping

This unit sits on the peripheral side of an 8-bit processor bus and manages one device's interrupt. Units are wired in a chain: each one's `chain_out` feeds the next one's `chain_in`, and the head of the chain has its `chain_in` tied high. A unit nearer the head has higher priority. When the unit's device asks for service, the unit holds it pending and pulls its active-low request line. During an acknowledge cycle, the highest-priority pending unit drives its vector byte onto the data bus and moves to in-service.

The unit watches opcode fetch cycles on the data bus. A fetch of 0xED followed by a fetch of 0x4D is the return-from-interrupt sequence. When the unit sees it while it is in service and its `chain_in` is high, it ends service and releases the chain. The return does not act as an acknowledge or as an interrupt enable. A pending unit stays pending through a return. Because a higher-priority unit can be acknowledged while a lower one is in service, and each return clears only the innermost routine, service routines nest.

The service state machine has three states:
- `SVC_IDLE`
- `SVC_PEND`
- `SVC_ACTIVE`

Its transitions are:
- request: `SVC_IDLE` to `SVC_PEND`, on `dev_req`.
- acknowledge: `SVC_PEND` to `SVC_ACTIVE`, on `iack` with `chain_in` high.
- return: `SVC_ACTIVE` to `SVC_IDLE`, on a decoded return with `chain_in` high.

The return decoder has two states, `DEC_IDLE` and `DEC_GOT_PREFIX`. Its transitions are:
- prefix: `DEC_IDLE` to `DEC_GOT_PREFIX`, on a fetch of 0xED.
- complete: `DEC_GOT_PREFIX` to `DEC_IDLE`, on a fetch of 0x4D, which produces a return hit.
- discard: `DEC_GOT_PREFIX` to `DEC_IDLE`, on a fetch of any other byte.

In any state, a cycle without a fetch leaves the decoder where it is.

Top module: `irq_chain_unit`

## Requirements
- R1: After reset, the unit is idle with no pending interrupt and the return decoder is empty. In this state `irq_n` is 1, `vec_oe` is 0, `chain_out` equals `chain_in`, and the vector register holds the parameter `VEC_RESET`.
- R2: A high `dev_req` in `SVC_IDLE` makes the unit pending from the next clock edge. `irq_n` is low exactly while the unit is pending and `chain_in` is high. `dev_req` in any other state is ignored.
- R3: `chain_out` is high only when `chain_in` is high and the unit is in `SVC_IDLE`. It is low while the unit is pending or in service.
- R4: In a cycle with `iack` high, a pending unit with `chain_in` high raises `vec_oe` and drives its vector on `vec_out` in that same cycle. From the next edge it is in service, so `irq_n` is 1 and `chain_out` is 0.
- R5: `iack` has no effect on a unit that is not pending or whose `chain_in` is low. In that case `vec_oe` stays 0 and `vec_out` is 0.
- R6: A fetch of 0xED followed by a fetch of 0x4D ends service from the edge that samples 0x4D, if the unit is in service with `chain_in` high. Cycles without a fetch may lie between the two fetches.
- R7: A unit in service whose `chain_in` is low ignores a return sequence and stays in service.
- R8: If the fetch after 0xED carries any byte other than 0x4D, the sequence is discarded. A later lone fetch of 0x4D does not end service.
- R9: Bytes on `data_in` in cycles with `fetch` low never advance the decoder.
- R10: A return sequence does not act on a pending unit. The unit stays pending with `irq_n` low.
- R11: A high `vec_wr` loads `vec_wdata` into the vector register from the next edge. That value is the one supplied on the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_in | input | 1 | Priority enable from the upstream unit |
| chain_out | output | 1 | Priority enable to the downstream unit |
| dev_req | input | 1 | Device service request |
| irq_n | output | 1 | Active-low interrupt request (open-drain style) |
| iack | input | 1 | Interrupt acknowledge cycle strobe |
| fetch | input | 1 | Opcode fetch cycle strobe, data valid |
| data_in | input | DATA_W | Data bus as seen by the unit |
| vec_out | output | DATA_W | Vector byte, zero when not driving |
| vec_oe | output | 1 | Vector drive enable |
| vec_wr | input | 1 | Vector register load strobe |
| vec_wdata | input | DATA_W | Vector register load value |

## Verification
`chain_out`, `irq_n` gating, `vec_oe` and `vec_out` are combinational. The bench checks them one time step after driving inputs, within the same cycle. State changes (request, acknowledge, return, vector load) appear after the edge that samples the stimulus. The bench drives inputs two time steps after a rising edge and checks the registered results right after the following edge. A return is therefore checked immediately after the edge that samples the 0x4D fetch, and the discard and no-fetch cases are checked at the same point.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef enum logic [1:0] {
        SVC_IDLE,
        SVC_PEND,
        SVC_ACTIVE
    } svc_state_t;

    typedef enum logic {
        DEC_IDLE,
        DEC_GOT_PREFIX
    } dec_state_t;
endpackage

// File: rtl/ret_decoder.sv
module ret_decoder
    import irq_chain_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] PREFIX_BYTE = 8'hED,
    parameter logic [DATA_W-1:0] RETURN_BYTE = 8'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic [DATA_W-1:0] data_in,
    output logic              ret_hit
);
    dec_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DEC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_IDLE:
                if (fetch && data_in == PREFIX_BYTE) state_d = DEC_GOT_PREFIX;
            DEC_GOT_PREFIX:
                if (fetch) state_d = DEC_IDLE;
            default: state_d = DEC_IDLE;
        endcase
    end

    always_comb begin
        ret_hit = 1'b0;
        unique case (state_q)
            DEC_IDLE:       ret_hit = 1'b0;
            DEC_GOT_PREFIX: ret_hit = fetch && (data_in == RETURN_BYTE);
            default:        ret_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/svc_fsm.sv
module svc_fsm
    import irq_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chain_in,
    input  logic       dev_req,
    input  logic       iack,
    input  logic       ret_hit,
    output svc_state_t state,
    output logic       irq_n,
    output logic       chain_out,
    output logic       grant
);
    svc_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE:   if (dev_req)             state_d = SVC_PEND;
            SVC_PEND:   if (iack && chain_in)    state_d = SVC_ACTIVE;
            SVC_ACTIVE: if (ret_hit && chain_in) state_d = SVC_IDLE;
            default:                             state_d = SVC_IDLE;
        endcase
    end

    always_comb begin
        irq_n     = 1'b1;
        chain_out = 1'b0;
        grant     = 1'b0;
        unique case (state_q)
            SVC_IDLE:   chain_out = chain_in;
            SVC_PEND: begin
                irq_n = !chain_in;
                grant = iack && chain_in;
            end
            SVC_ACTIVE: chain_out = 1'b0;
            default:    chain_out = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/vec_reg.sv
module vec_reg #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] VEC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= VEC_RESET;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit
    import irq_chain_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] VEC_RESET = '0,
    parameter logic [DATA_W-1:0] PREFIX_BYTE = 8'hED,
    parameter logic [DATA_W-1:0] RETURN_BYTE = 8'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_in,
    output logic              chain_out,
    input  logic              dev_req,
    output logic              irq_n,
    input  logic              iack,
    input  logic              fetch,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_oe,
    input  logic              vec_wr,
    input  logic [DATA_W-1:0] vec_wdata
);
    logic              ret_hit;
    logic              grant;
    logic [DATA_W-1:0] vec_q;
    svc_state_t        svc_state;

    ret_decoder #(
        .DATA_W(DATA_W), .PREFIX_BYTE(PREFIX_BYTE), .RETURN_BYTE(RETURN_BYTE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .fetch(fetch), .data_in(data_in), .ret_hit(ret_hit)
    );

    svc_fsm u_svc (
        .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .dev_req(dev_req),
        .iack(iack), .ret_hit(ret_hit), .state(svc_state), .irq_n(irq_n),
        .chain_out(chain_out), .grant(grant)
    );

    vec_reg #(.DATA_W(DATA_W), .VEC_RESET(VEC_RESET)) u_vec (
        .clk(clk), .rst_n(rst_n), .wr(vec_wr), .wdata(vec_wdata), .q(vec_q)
    );

    assign vec_oe  = grant;
    assign vec_out = grant ? vec_q : '0;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk
    import irq_chain_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       chain_in,
    input logic       chain_out,
    input logic       irq_n,
    input logic       iack,
    input logic       vec_oe,
    input svc_state_t svc_state
);
    // R3
    chain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out |-> chain_in);

    // R3
    chain_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_state != SVC_IDLE) |-> !chain_out);

    // R2
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> chain_in);

    // R4
    vec_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |=> (svc_state == SVC_ACTIVE));

    // R5
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack && chain_in) |-> !vec_oe);

    // R7
    ret_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_state == SVC_ACTIVE && !chain_in) |=> (svc_state == SVC_ACTIVE));

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_state == SVC_PEND && !iack) |=> (svc_state == SVC_PEND));
endmodule

bind irq_chain_unit irq_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .chain_out(chain_out),
    .irq_n(irq_n), .iack(iack), .vec_oe(vec_oe), .svc_state(svc_state)
);

// File: tb/tb_irq_chain_unit.sv
`timescale 1ns/1ps
module tb_irq_chain_unit;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 0, req_b = 0;
    logic iack = 0, fetch = 0, vec_wr = 0;
    logic [DW-1:0] data = '0;
    logic [DW-1:0] wdata = '0;
    logic a_out, b_out, a_irq, b_irq, a_oe, b_oe;
    logic [DW-1:0] a_vec, b_vec;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    irq_chain_unit #(.DATA_W(DW), .VEC_RESET(8'h11)) dut (
        .clk(clk), .rst_n(rst_n), .chain_in(1'b1), .chain_out(a_out),
        .dev_req(req_a), .irq_n(a_irq), .iack(iack), .fetch(fetch),
        .data_in(data), .vec_out(a_vec), .vec_oe(a_oe),
        .vec_wr(vec_wr), .vec_wdata(wdata)
    );

    irq_chain_unit #(.DATA_W(DW), .VEC_RESET(8'h11)) dut_lo (
        .clk(clk), .rst_n(rst_n), .chain_in(a_out), .chain_out(b_out),
        .dev_req(req_b), .irq_n(b_irq), .iack(iack), .fetch(fetch),
        .data_in(data), .vec_out(b_vec), .vec_oe(b_oe),
        .vec_wr(1'b0), .vec_wdata(8'h00)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [DW-1:0] b);
        fetch = 1; data = b;
        tick();
        fetch = 0; data = '0;
    endtask

    task automatic do_return();
        do_fetch(8'hED);
        do_fetch(8'h4D);
    endtask

    task automatic do_ack();
        iack = 1;
        tick();
        iack = 0;
    endtask

    task automatic t_reset();
        chk("R1 a irq_n", a_irq, 1);
        chk("R1 a chain_out", a_out, 1);
        chk("R1 b chain_out", b_out, 1);
        chk("R1 vec_oe", a_oe | b_oe, 0);
        req_b = 1; tick(); req_b = 0;
        iack = 1; #1;
        chk("R1 reset vector", b_vec, 8'h11);
        tick(); iack = 0;
        do_return();
        chk("R1 cleanup b idle", b_out, 1);
    endtask

    task automatic t_vec_load();
        vec_wr = 1; wdata = 8'h20; tick(); vec_wr = 0;
        req_a = 1; tick(); req_a = 0;
        iack = 1; #1;
        chk("R11 loaded vector", a_vec, 8'h20);
        tick(); iack = 0;
        do_return();
        chk("R11 cleanup", a_out, 1);
    endtask

    task automatic t_single();
        req_b = 1; tick(); req_b = 0;
        chk("R2 b irq_n low", b_irq, 0);
        chk("R2 a irq_n high", a_irq, 1);
        chk("R3 a chain_out", a_out, 1);
        chk("R3 b chain_out pending", b_out, 0);
        iack = 1; #1;
        chk("R4 b vec_oe", b_oe, 1);
        chk("R4 b vector", b_vec, 8'h11);
        chk("R5 a vec_oe idle", a_oe, 0);
        chk("R5 a vec_out", a_vec, 0);
        tick(); iack = 0;
        chk("R4 b irq_n released", b_irq, 1);
        chk("R4 b chain_out in service", b_out, 0);
        req_b = 1; tick(); req_b = 0;
        chk("R2 req ignored in service", b_irq, 1);
        do_fetch(8'hED);
        chk("R6 not yet cleared", b_out, 0);
        tick();
        do_fetch(8'h4D);
        chk("R6 b cleared", b_out, 1);
    endtask

    task automatic t_nest();
        req_b = 1; tick(); req_b = 0;
        do_ack();
        req_a = 1; tick(); req_a = 0;
        chk("R2 a irq_n low", a_irq, 0);
        chk("R3 a chain_out pending", a_out, 0);
        iack = 1; #1;
        chk("R4 a vec_oe", a_oe, 1);
        chk("R4 a vector", a_vec, 8'h20);
        chk("R5 b vec_oe", b_oe, 0);
        tick(); iack = 0;
        do_return();
        chk("R6 a cleared", a_out, 1);
        chk("R7 b kept in service", b_out, 0);
        do_return();
        chk("R6 b cleared after nest", b_out, 1);
    endtask

    task automatic t_blocked_req();
        req_a = 1; tick(); req_a = 0;
        do_ack();
        req_b = 1; tick(); req_b = 0;
        chk("R2 b irq_n gated", b_irq, 1);
        iack = 1; #1;
        chk("R5 b vec_oe gated", b_oe, 0);
        tick(); iack = 0;
        do_return();
        chk("R2 b irq_n after release", b_irq, 0);
        do_ack();
        do_return();
        chk("R6 b cleared", b_out, 1);
    endtask

    task automatic t_discard();
        req_b = 1; tick(); req_b = 0;
        do_ack();
        do_fetch(8'hED);
        do_fetch(8'h00);
        do_fetch(8'h4D);
        chk("R8 discarded sequence", b_out, 0);
        data = 8'hED; tick(); data = 8'h00;
        do_fetch(8'h4D);
        chk("R9 non-fetch ignored", b_out, 0);
        do_return();
        chk("R6 cleared after discard", b_out, 1);
    endtask

    task automatic t_pend_ret();
        iack = 1; #1;
        chk("R5 iack idle", a_oe | b_oe, 0);
        tick(); iack = 0;
        chk("R5 a stays idle", a_out, 1);
        req_a = 1; tick(); req_a = 0;
        do_return();
        chk("R10 a still pending", a_irq, 0);
        do_ack();
        do_return();
        chk("R10 cleanup", a_out, 1);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_vec_load();
        t_single();
        t_nest();
        t_blocked_req();
        t_discard();
        t_pend_ret();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule